// File: doc/BRIEF.md
# Unaligned Physical Access Splitter

This block sits between an address-translation stage and a memory or I/O port. It accepts one physical access of a byte, a word or a longword and turns it into the exact set of fragment transfers needed to perform it. Each fragment stays inside a single longword. Each one carries an exact byte count of 1 to 4. No fragment touches a byte outside the access. This matters for I/O targets, where an extra read can have side effects and where a byte write is not the same as a word read-modify-write.

An access that is naturally aligned goes out as one fragment of full length. An unaligned longword, or a word at byte offset 3, spills into the next longword and becomes two fragments, issued low part first. The second fragment always starts at byte 0 of its longword. That longword's address is either supplied by the requester, for the case where the access crosses a page, or derived from the first address. Fragment data is right-justified in both directions. Write data is sliced into the fragments. Read data from the fragments is glued back into a single right-justified result.

Each fragment is held on the port until the target acknowledges it. Completion is signalled with a one-cycle pulse.

Top module: `uacc_splitter`

## Requirements
- R1: After reset, req_ready_o is 1, frag_valid_o is 0 and done_o is 0.
- R2: An aligned access is issued as one fragment at req_addr_i with length equal to the access size. Aligned means a byte at any offset, a word at offset 0 or 2, or a longword at offset 0. Size codes are 0 = byte, 1 = word, 2 = longword; offset is req_addr_i[1:0].
- R3: A longword at offset k (1..3) is issued as two fragments. The first is 4-k bytes at req_addr_i. The second is k bytes at the second-longword address, whose bits [1:0] are 0.
- R4: A word at offset 1 is issued as one 2-byte fragment at req_addr_i.
- R5: A word at offset 3 is issued as two 1-byte fragments. The first is at req_addr_i and carries the low byte. The second is at the second-longword address and carries the high byte.
- R6: The second-longword address depends on req_cross_i. When req_cross_i is 1, it is req_addr2_i with bits [1:0] cleared. When req_cross_i is 0, it is (req_addr_i + 4) modulo 2^PA_W with bits [1:0] cleared.
- R7: For a read, rdata_o equals (first fragment data) OR (second fragment data shifted left by 8 times the first fragment length), truncated to 32 bits. Bits of frag_rdata_i above the fragment length are ignored.
- R8: Each fragment is driven with right-justified write data. For the first fragment this is req_wdata_i masked to the fragment length. For the second fragment it is req_wdata_i shifted right by 8 times the first length, then masked. frag_be_o equals (2^len - 1) shifted left by frag_addr_o[1:0].
- R9: A fragment stays valid and unchanged until frag_ack_i. The next fragment is presented in the cycle after the acknowledge. done_o is high for exactly one cycle, in the cycle after the last acknowledge. req_ready_o is 0 from acceptance until done_o has dropped, and requests offered while busy are ignored.
- R10: Size code 3 is handled exactly as a longword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request |
| req_ready_o | output | 1 | Block idle, request taken this cycle |
| req_size_i | input | 2 | 0 byte, 1 word, 2 or 3 longword |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | PA_W | First physical byte address |
| req_addr2_i | input | PA_W | Physical address in the second longword, used on page cross |
| req_cross_i | input | 1 | Use req_addr2_i for the second fragment |
| req_wdata_i | input | 32 | Right-justified write data |
| frag_valid_o | output | 1 | Fragment presented |
| frag_ack_i | input | 1 | Target accepts fragment (and returns read data) |
| frag_write_o | output | 1 | Fragment direction |
| frag_addr_o | output | PA_W | Fragment byte address |
| frag_len_o | output | 3 | Fragment length in bytes, 1..4 |
| frag_be_o | output | 4 | Byte lanes touched in the longword |
| frag_wdata_o | output | 32 | Right-justified, masked fragment write data |
| frag_rdata_i | input | 32 | Right-justified fragment read data |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Merged read result (0 after a write) |

## Verification
A wrong split plan shows up at the first fragment. The bench sees a wrong length, byte-enable or address in the cycle after acceptance, or a missing or extra fragment one acknowledge later. A corrupted held low half or a wrong merge shift shows only in rdata_o, in the cycle done_o pulses. A write slicing error shows as a byte mismatch in the target memory model after completion. A hold or sequencing fault shows as a fragment that changes during a stalled acknowledge, or as a done pulse that arrives early, late or for longer than one cycle.

// File: rtl/uacc_pkg.sv
package uacc_pkg;

  localparam int unsigned LW_BYTES = 4;
  localparam int unsigned LW_BITS  = 8 * LW_BYTES;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } uacc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2,
    ST_DONE = 2'd3
  } uacc_state_e;

  function automatic logic [LW_BITS-1:0] len_mask(input logic [2:0] len);
    logic [LW_BITS-1:0] m;
    case (len)
      3'd1:    m = 32'h0000_00FF;
      3'd2:    m = 32'h0000_FFFF;
      3'd3:    m = 32'h00FF_FFFF;
      default: m = 32'hFFFF_FFFF;
    endcase
    return m;
  endfunction

  function automatic logic [LW_BYTES-1:0] lane_mask(input logic [2:0] len, input logic [1:0] off);
    logic [LW_BYTES-1:0] b;
    case (len)
      3'd1:    b = 4'b0001;
      3'd2:    b = 4'b0011;
      3'd3:    b = 4'b0111;
      default: b = 4'b1111;
    endcase
    return b << off;
  endfunction

endpackage

// File: rtl/uacc_plan.sv
// Split plan: fragment lengths for a given size and byte offset.
module uacc_plan
  import uacc_pkg::*;
(
  input  uacc_size_e  size_i,
  input  logic [1:0]  off_i,
  output logic [2:0]  len_lo_o,
  output logic [2:0]  len_hi_o,
  output logic        two_o
);

  always_comb begin
    len_lo_o = 3'd4;
    len_hi_o = 3'd0;
    unique case (size_i)
      SZ_BYTE: len_lo_o = 3'd1;
      SZ_WORD: begin
        if (off_i == 2'd3) begin
          len_lo_o = 3'd1;
          len_hi_o = 3'd1;
        end else begin
          len_lo_o = 3'd2;
        end
      end
      default: begin
        len_lo_o = 3'd4 - {1'b0, off_i};
        len_hi_o = {1'b0, off_i};
      end
    endcase
    two_o = (len_hi_o != 3'd0);
  end

endmodule

// File: rtl/uacc_hiaddr.sv
// Second-longword address: supplied on page cross, else next longword.
module uacc_hiaddr #(
  parameter int unsigned PA_W = 30
) (
  input  logic [PA_W-1:0] addr_i,
  input  logic [PA_W-1:0] addr2_i,
  input  logic            cross_i,
  output logic [PA_W-1:0] hi_addr_o
);

  localparam logic [PA_W-1:0] LW_STEP  = PA_W'(4);
  localparam logic [PA_W-1:0] LW_ALIGN = ~PA_W'(3);

  logic [PA_W-1:0] next_lw;

  always_comb begin
    next_lw   = addr_i + LW_STEP;
    hi_addr_o = (cross_i ? addr2_i : next_lw) & LW_ALIGN;
  end

endmodule

// File: rtl/uacc_merge.sv
// Read result assembly from right-justified fragments.
module uacc_merge
  import uacc_pkg::*;
(
  input  logic [LW_BITS-1:0] lo_i,
  input  logic [LW_BITS-1:0] hi_i,
  input  logic [2:0]         len_lo_i,
  input  logic [2:0]         len_hi_i,
  output logic [LW_BITS-1:0] data_o
);

  logic [5:0]         sh;
  logic [LW_BITS-1:0] hi_m;

  always_comb begin
    sh     = {len_lo_i, 3'b000};
    hi_m   = hi_i & len_mask(len_hi_i);
    data_o = lo_i | (hi_m << sh);
  end

endmodule

// File: rtl/uacc_splitter.sv
module uacc_splitter
  import uacc_pkg::*;
#(
  parameter int unsigned PA_W = 30
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [1:0]      req_size_i,
  input  logic            req_write_i,
  input  logic [PA_W-1:0] req_addr_i,
  input  logic [PA_W-1:0] req_addr2_i,
  input  logic            req_cross_i,
  input  logic [31:0]     req_wdata_i,
  output logic            frag_valid_o,
  input  logic            frag_ack_i,
  output logic            frag_write_o,
  output logic [PA_W-1:0] frag_addr_o,
  output logic [2:0]      frag_len_o,
  output logic [3:0]      frag_be_o,
  output logic [31:0]     frag_wdata_o,
  input  logic [31:0]     frag_rdata_i,
  output logic            done_o,
  output logic [31:0]     rdata_o
);

  uacc_state_e     state_q;
  uacc_size_e      size_q;
  logic            wr_q;
  logic [PA_W-1:0] addr_q, hi_q;
  logic [31:0]     wdata_q, rlo_q, rdata_q;

  logic [PA_W-1:0] hi_addr;
  logic [2:0]      len_lo, len_hi;
  logic            two;
  logic [31:0]     rd_lo_m, merged;
  logic            in_hi;

  uacc_hiaddr #(.PA_W(PA_W)) u_hiaddr (
    .addr_i    (req_addr_i),
    .addr2_i   (req_addr2_i),
    .cross_i   (req_cross_i),
    .hi_addr_o (hi_addr)
  );

  uacc_plan u_plan (
    .size_i   (size_q),
    .off_i    (addr_q[1:0]),
    .len_lo_o (len_lo),
    .len_hi_o (len_hi),
    .two_o    (two)
  );

  uacc_merge u_merge (
    .lo_i     (rlo_q),
    .hi_i     (frag_rdata_i),
    .len_lo_i (len_lo),
    .len_hi_i (len_hi),
    .data_o   (merged)
  );

  assign rd_lo_m = frag_rdata_i & len_mask(len_lo);
  assign in_hi   = (state_q == ST_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      size_q  <= SZ_BYTE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      hi_q    <= '0;
      wdata_q <= '0;
      rlo_q   <= '0;
      rdata_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          size_q  <= uacc_size_e'(req_size_i);
          wr_q    <= req_write_i;
          addr_q  <= req_addr_i;
          hi_q    <= hi_addr;
          wdata_q <= req_wdata_i;
          state_q <= ST_LO;
        end
        ST_LO: if (frag_ack_i) begin
          rlo_q <= rd_lo_m;
          if (two) begin
            state_q <= ST_HI;
          end else begin
            rdata_q <= wr_q ? '0 : rd_lo_m;
            state_q <= ST_DONE;
          end
        end
        ST_HI: if (frag_ack_i) begin
          rdata_q <= wr_q ? '0 : merged;
          state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready_o  = (state_q == ST_IDLE);
    frag_valid_o = (state_q == ST_LO) || in_hi;
    frag_write_o = wr_q;
    frag_addr_o  = in_hi ? hi_q : addr_q;
    frag_len_o   = in_hi ? len_hi : len_lo;
    frag_be_o    = lane_mask(frag_len_o, frag_addr_o[1:0]);
    frag_wdata_o = in_hi ? ((wdata_q >> {len_lo, 3'b000}) & len_mask(len_hi))
                         : (wdata_q & len_mask(len_lo));
    done_o       = (state_q == ST_DONE);
    rdata_o      = rdata_q;
  end

  AST_FRAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frag_valid_o && !frag_ack_i |=> frag_valid_o && $stable(frag_addr_o)
      && $stable(frag_len_o) && $stable(frag_wdata_o)); // R9
  AST_HI_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_hi |-> frag_addr_o[1:0] == 2'b00); // R3
  AST_IN_LONGWORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frag_valid_o |-> ({2'b00, frag_addr_o[1:0]} + {1'b0, frag_len_o}) <= 4'd4); // R8
  AST_BE_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frag_valid_o |-> $countones(frag_be_o) == int'(frag_len_o)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(frag_valid_o && frag_ack_i)); // R9
  AST_NOT_READY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frag_valid_o || done_o) |-> !req_ready_o); // R9

endmodule

// File: tb/tb_uacc_splitter.sv
module tb_uacc_splitter;

  localparam int unsigned PA_W = 30;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            req_valid_i = 1'b0;
  logic            req_ready_o;
  logic [1:0]      req_size_i = '0;
  logic            req_write_i = 1'b0;
  logic [PA_W-1:0] req_addr_i = '0;
  logic [PA_W-1:0] req_addr2_i = '0;
  logic            req_cross_i = 1'b0;
  logic [31:0]     req_wdata_i = '0;
  logic            frag_valid_o, frag_write_o, frag_ack_i = 1'b0;
  logic [PA_W-1:0] frag_addr_o;
  logic [2:0]      frag_len_o;
  logic [3:0]      frag_be_o;
  logic [31:0]     frag_wdata_o, frag_rdata_i = '0;
  logic            done_o;
  logic [31:0]     rdata_o;

  int total = 0;
  int bad   = 0;
  logic [31:0] mem [16];

  always #4 clk = ~clk;

  uacc_splitter #(.PA_W(PA_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_size_i(req_size_i), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .req_addr2_i(req_addr2_i),
    .req_cross_i(req_cross_i), .req_wdata_i(req_wdata_i),
    .frag_valid_o(frag_valid_o), .frag_ack_i(frag_ack_i),
    .frag_write_o(frag_write_o), .frag_addr_o(frag_addr_o),
    .frag_len_o(frag_len_o), .frag_be_o(frag_be_o),
    .frag_wdata_o(frag_wdata_o), .frag_rdata_i(frag_rdata_i),
    .done_o(done_o), .rdata_o(rdata_o)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int n);
    return (n >= 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * n)) - 32'h1);
  endfunction

  function automatic logic [7:0] getb(input logic [PA_W-1:0] a);
    return mem[a[5:2]][8*a[1:0] +: 8];
  endfunction

  task automatic mem_init();
    for (int i = 0; i < 16; i++) mem[i] = 32'h0302_0100 + 32'h0404_0404 * i;
  endtask

  task automatic do_access(input logic [1:0] sz, input logic [PA_W-1:0] a,
                           input logic [PA_W-1:0] a2, input bit cr, input bit wr,
                           input logic [31:0] wd, input int dly, input bit poke,
                           input string rq);
    int n0, n1, nfr, off;
    logic [PA_W-1:0] hi, t;
    logic [PA_W-1:0] fa [2];
    int fl [2];
    logic [31:0] exp_rd, ewd, resp;
    logic [3:0]  ebe;
    logic [31:0] emem [16];
    off = int'(a[1:0]);
    n1 = 0;
    case (sz)
      2'd0: n0 = 1;
      2'd1: if (off == 3) begin n0 = 1; n1 = 1; end else n0 = 2;
      default: if (off == 0) n0 = 4; else begin n0 = 4 - off; n1 = off; end
    endcase
    hi = cr ? (a2 & ~PA_W'(3)) : ((a + PA_W'(4)) & ~PA_W'(3));
    fa[0] = a; fl[0] = n0; fa[1] = hi; fl[1] = n1;
    nfr = (n1 != 0) ? 2 : 1;
    exp_rd = '0;
    emem = mem;
    for (int i = 0; i < n0; i++) begin
      t = a + PA_W'(i);
      exp_rd[8*i +: 8] = getb(t);
      if (wr) emem[t[5:2]][8*t[1:0] +: 8] = wd[8*i +: 8];
    end
    for (int i = 0; i < n1; i++) begin
      t = hi + PA_W'(i);
      exp_rd[8*(n0+i) +: 8] = getb(t);
      if (wr) emem[t[5:2]][8*t[1:0] +: 8] = wd[8*(n0+i) +: 8];
    end
    @(negedge clk);
    req_valid_i = 1'b1; req_size_i = sz; req_write_i = wr; req_addr_i = a;
    req_addr2_i = a2; req_cross_i = cr; req_wdata_i = wd;
    @(negedge clk);
    if (poke) begin
      req_addr_i = a ^ PA_W'(5); req_size_i = 2'd0; req_write_i = ~wr;
      req_wdata_i = ~wd;
    end else req_valid_i = 1'b0;
    for (int k = 0; k < nfr; k++) begin
      ewd = (wd >> (8 * (k != 0 ? n0 : 0))) & mk(fl[k]);
      ebe = 4'(((1 << fl[k]) - 1) << fa[k][1:0]);
      chk(frag_valid_o == 1'b1, rq, "frag_valid", 64'(frag_valid_o), 64'd1);
      chk(frag_addr_o == fa[k], rq, "frag_addr", 64'(frag_addr_o), 64'(fa[k]));
      chk(int'(frag_len_o) == fl[k], rq, "frag_len", 64'(frag_len_o), 64'(fl[k]));
      chk(frag_be_o == ebe, rq, "frag_be R8", 64'(frag_be_o), 64'(ebe));
      chk(frag_write_o == wr, rq, "frag_write", 64'(frag_write_o), 64'(wr));
      if (wr) chk(frag_wdata_o == ewd, rq, "frag_wdata R8", 64'(frag_wdata_o), 64'(ewd));
      for (int d = 0; d < dly; d++) begin
        @(negedge clk);
        chk(frag_valid_o && frag_addr_o == fa[k] && int'(frag_len_o) == fl[k],
            "R9", "hold during stall", 64'(frag_addr_o), 64'(fa[k]));
      end
      resp = ((mem[frag_addr_o[5:2]] >> (8 * frag_addr_o[1:0])) & mk(fl[k]))
           | (32'hDEAD_BEEF & ~mk(fl[k]));
      if (frag_write_o) begin
        for (int b = 0; b < 4; b++)
          if (frag_be_o[b])
            mem[frag_addr_o[5:2]][8*b +: 8] = frag_wdata_o[8*(b - int'(frag_addr_o[1:0])) +: 8];
      end
      frag_ack_i = 1'b1; frag_rdata_i = resp;
      @(negedge clk);
      frag_ack_i = 1'b0; frag_rdata_i = 32'h5A5A_5A5A;
    end
    chk(done_o == 1'b1 && frag_valid_o == 1'b0, "R9", "done after last ack",
        64'({done_o, frag_valid_o}), 64'h2);
    if (!wr) chk(rdata_o == exp_rd, rq, "rdata R7", 64'(rdata_o), 64'(exp_rd));
    else begin
      for (int i = 0; i < 16; i++)
        if (mem[i] != emem[i]) chk(1'b0, rq, "memory after write R8", 64'(mem[i]), 64'(emem[i]));
      chk(1'b1, rq, "memory after write", 0, 0);
    end
    req_valid_i = 1'b0;
    @(negedge clk);
    chk(!done_o && req_ready_o && !frag_valid_o, "R9", "done one cycle, idle",
        64'({done_o, req_ready_o, frag_valid_o}), 64'h2);
  endtask

  task automatic t_reset();
    chk(req_ready_o == 1'b1, "R1", "ready after reset", 64'(req_ready_o), 64'd1);
    chk(frag_valid_o == 1'b0, "R1", "no fragment after reset", 64'(frag_valid_o), 64'd0);
    chk(done_o == 1'b0, "R1", "no done after reset", 64'(done_o), 64'd0);
  endtask

  task automatic t_aligned();
    do_access(2'd0, 30'h0000_0011, '0, 0, 0, 0, 0, 0, "R2");
    do_access(2'd0, 30'h0000_0013, '0, 0, 1, 32'h0000_00C3, 0, 0, "R2");
    do_access(2'd1, 30'h0000_0022, '0, 0, 1, 32'h0000_BEEF, 0, 0, "R2");
    do_access(2'd1, 30'h0000_0008, '0, 0, 0, 0, 0, 0, "R2");
    do_access(2'd2, 30'h0000_0030, '0, 0, 0, 0, 0, 0, "R2");
  endtask

  task automatic t_long_unaligned();
    for (int o = 1; o < 4; o++) begin
      do_access(2'd2, PA_W'(32'h14 + o), '0, 0, 0, 0, 0, 0, "R3");
      do_access(2'd2, PA_W'(32'h24 + o), '0, 0, 1, 32'hA1B2_C3D4, 0, 0, "R3");
    end
  endtask

  task automatic t_word_off1();
    do_access(2'd1, 30'h0000_0005, '0, 0, 0, 0, 0, 0, "R4");
    do_access(2'd1, 30'h0000_0039, '0, 0, 1, 32'h0000_7E81, 0, 0, "R4");
  endtask

  task automatic t_word_off3();
    do_access(2'd1, 30'h0000_000B, '0, 0, 0, 0, 0, 0, "R5");
    do_access(2'd1, 30'h0000_002F, '0, 0, 1, 32'h0000_6C93, 0, 0, "R5");
  endtask

  task automatic t_second_addr();
    do_access(2'd2, 30'h0000_0016, 30'h0000_0035, 1, 0, 0, 0, 0, "R6");
    do_access(2'd1, 30'h0000_0007, 30'h0000_003E, 1, 1, 32'h0000_F00D, 0, 0, "R6");
    do_access(2'd2, 30'h3FFF_FFFD, '0, 0, 0, 0, 0, 0, "R6");
  endtask

  task automatic t_stall_busy();
    do_access(2'd2, 30'h0000_0019, '0, 0, 1, 32'h1357_9BDF, 3, 1, "R9");
    do_access(2'd1, 30'h0000_0003, '0, 0, 0, 0, 2, 1, "R9");
  endtask

  task automatic t_rsvd_size();
    do_access(2'd3, 30'h0000_0012, '0, 0, 0, 0, 0, 0, "R10");
    do_access(2'd3, 30'h0000_0020, '0, 0, 1, 32'hCAFE_F00D, 0, 0, "R10");
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    mem_init();
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_aligned();
    t_long_unaligned();
    t_word_off1();
    t_word_off3();
    t_second_addr();
    t_stall_busy();
    t_rsvd_size();
    finish_run();
  end

endmodule